// File: doc/BRIEF.md
# Outbound address window translator

This block sits between a CPU-side address bus and an outbound PCIe-style request path. It turns each CPU address into a bus address and an action word that the request path uses. Software programs eight windows through a 32-bit register port. Each window holds a 64-bit match address, a 64-bit remap address, a 64-bit mask and a 32-bit action word. A window is switched on by bit 0 of its match-low register.

For each accepted request the block compares the address against every enabled window at the same time. The lowest-numbered window that hits supplies the remap and action word. An address that no window claims keeps its original value and takes the default action word. The result is registered and appears one cycle after the request.

Top module: `ob_xlate`

## Requirements
- R1: After reset every window register and the default action register read 0, and `rsp_valid_o` is low.
- R2: Window w (0..7) has registers at byte offset 0x4C00 + 0x20*w + k. The values of k are: 0x00 match low, 0x04 match high, 0x08 remap low, 0x0C remap high, 0x10 mask low, 0x14 mask high, 0x18 action. The default action register is at 0x4CFC. Written values read back, and every other offset reads 0 and ignores writes.
- R3: Bits 15:0 of each mask always read 0, whatever was written to them. As a result, bits 15:0 of a translated address always equal bits 15:0 of the request address.
- R4: Bit 0 of a window's match-low register enables that window. A window whose enable bit is 0 never hits, so writing zeros to its registers switches it off.
- R5: An enabled window hits address A when (A AND mask) equals (match AND mask).
- R6: On a hit the translated address is (A AND NOT mask) OR (remap AND mask).
- R7: When several enabled windows hit, the lowest-numbered one supplies the address, the action word and the index.
- R8: On a miss `rsp_hit_o` is 0, the address passes through unchanged, and `rsp_action_o` is the default action word.
- R9: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. The response fields hold their values while no request is presented.
- R10: The action word is returned exactly as stored, with no interpretation. This covers the type code in bits 3:0 (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message) and the attribute bits: 11 enable, 10:8 traffic class, 7 relaxed ordering, 6 no-snoop, 5 poison, 4 ID-based ordering.
- R11: `rsp_win_o` gives the index of the winning window on a hit and 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 64 | CPU-side request address |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_addr_o | output | 64 | Translated bus address |
| rsp_action_o | output | 32 | Action word of the winning window, or the default |
| rsp_hit_o | output | 1 | Some enabled window claimed the request |
| rsp_win_o | output | 3 | Index of the winning window |

## Verification
The bench builds the block with its defaults: eight windows, 64-bit addresses, a 16-bit register offset and a 64 KiB minimum granule. With these values the full register map is in reach, including the default action slot that shares window 7's block, and every window index can take part in the priority choice. The windows are programmed with masks of different sizes, so the bench can cover overlapping windows, matches that depend on the high address word, the edges of each region, and disabled windows whose match values would otherwise claim the address.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  // word slot inside a 0x20-byte window block
  typedef enum logic [2:0] {
    SLOT_MATCH_LO = 3'd0,
    SLOT_MATCH_HI = 3'd1,
    SLOT_REMAP_LO = 3'd2,
    SLOT_REMAP_HI = 3'd3,
    SLOT_MASK_LO  = 3'd4,
    SLOT_MASK_HI  = 3'd5,
    SLOT_ACTION   = 3'd6,
    SLOT_SPARE    = 3'd7
  } slot_e;

  localparam int unsigned BLK_LG = 5;  // 32-byte block per window
  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
  import ob_xlate_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 8,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned REG_AW   = 16,
  parameter int unsigned MASK_LSB = 16,
  parameter logic [REG_AW-1:0] WIN_BASE = 16'h4C00
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_wr_i,
  input  logic [REG_AW-1:0]                reg_addr_i,
  input  logic [WORD_W-1:0]                reg_wdata_i,
  output logic [WORD_W-1:0]                reg_rdata_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   match_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   remap_o,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   mask_o,
  output logic [NUM_WIN-1:0][WORD_W-1:0]   action_o,
  output logic [WORD_W-1:0]                def_action_o
);
  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int unsigned HI_W  = ADDR_W - WORD_W;
  localparam logic [REG_AW-1:0] WIN_SPAN = REG_AW'(NUM_WIN << BLK_LG);
  localparam logic [REG_AW-1:0] DEF_ADDR = WIN_BASE + WIN_SPAN - REG_AW'(4);

  logic [REG_AW-1:0] off;
  logic              in_win, is_def;
  logic [IDX_W-1:0]  widx;
  slot_e             slot;

  assign off    = reg_addr_i - WIN_BASE;
  assign is_def = (reg_addr_i == DEF_ADDR);
  assign in_win = (reg_addr_i >= WIN_BASE) && (off < WIN_SPAN) && (off[1:0] == 2'b00);
  assign widx   = off[BLK_LG +: IDX_W];
  assign slot   = slot_e'(off[BLK_LG-1:2]);

  logic [NUM_WIN-1:0][ADDR_W-1:0] match_q, remap_q, mask_q;
  logic [NUM_WIN-1:0][WORD_W-1:0] act_q;
  logic [WORD_W-1:0]              def_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic wr_w;
    assign wr_w = reg_wr_i && in_win && !is_def && (widx == IDX_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        match_q[w] <= '0;
        remap_q[w] <= '0;
        mask_q[w]  <= '0;
        act_q[w]   <= '0;
      end else if (wr_w) begin
        unique case (slot)
          SLOT_MATCH_LO: match_q[w][WORD_W-1:0]      <= reg_wdata_i;
          SLOT_MATCH_HI: match_q[w][ADDR_W-1:WORD_W] <= reg_wdata_i[HI_W-1:0];
          SLOT_REMAP_LO: remap_q[w][WORD_W-1:0]      <= reg_wdata_i;
          SLOT_REMAP_HI: remap_q[w][ADDR_W-1:WORD_W] <= reg_wdata_i[HI_W-1:0];
          SLOT_MASK_LO:  mask_q[w][WORD_W-1:0]       <= {reg_wdata_i[WORD_W-1:MASK_LSB], {MASK_LSB{1'b0}}};
          SLOT_MASK_HI:  mask_q[w][ADDR_W-1:WORD_W]  <= reg_wdata_i[HI_W-1:0];
          SLOT_ACTION:   act_q[w]                    <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 def_q <= '0;
    else if (reg_wr_i && is_def) def_q <= reg_wdata_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_def) begin
      reg_rdata_o = def_q;
    end else if (in_win) begin
      unique case (slot)
        SLOT_MATCH_LO: reg_rdata_o = match_q[widx][WORD_W-1:0];
        SLOT_MATCH_HI: reg_rdata_o = WORD_W'(match_q[widx][ADDR_W-1:WORD_W]);
        SLOT_REMAP_LO: reg_rdata_o = remap_q[widx][WORD_W-1:0];
        SLOT_REMAP_HI: reg_rdata_o = WORD_W'(remap_q[widx][ADDR_W-1:WORD_W]);
        SLOT_MASK_LO:  reg_rdata_o = mask_q[widx][WORD_W-1:0];
        SLOT_MASK_HI:  reg_rdata_o = WORD_W'(mask_q[widx][ADDR_W-1:WORD_W]);
        SLOT_ACTION:   reg_rdata_o = act_q[widx];
        default:       reg_rdata_o = '0;
      endcase
    end
  end

  assign match_o      = match_q;
  assign remap_o      = remap_q;
  assign mask_o       = mask_q;
  assign action_o     = act_q;
  assign def_action_o = def_q;
endmodule

// File: rtl/ob_xlate_hit.sv
module ob_xlate_hit #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] match_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              hit_o
);
  // bit 0 of match is the enable; mask bit 0 is always clear so it never compares
  assign hit_o = match_i[0] && ((addr_i & mask_i) == (match_i & mask_i));
endmodule

// File: rtl/ob_xlate_sel.sv
module ob_xlate_sel #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned ACT_W   = 32,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_WIN-1:0]              hit_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  remap_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  mask_i,
  input  logic [NUM_WIN-1:0][ACT_W-1:0]   action_i,
  input  logic [ACT_W-1:0]                def_action_i,
  output logic [ADDR_W-1:0]               addr_o,
  output logic [ACT_W-1:0]                action_o,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                win_o
);
  always_comb begin
    addr_o   = addr_i;
    action_o = def_action_i;
    hit_o    = 1'b0;
    win_o    = '0;
    // walk downward so the lowest index is assigned last
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) begin
        addr_o   = (addr_i & ~mask_i[w]) | (remap_i[w] & mask_i[w]);
        action_o = action_i[w];
        hit_o    = 1'b1;
        win_o    = IDX_W'(w);
      end
    end
  end
endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
  import ob_xlate_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 8,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned REG_AW   = 16,
  parameter int unsigned MASK_LSB = 16,
  parameter logic [REG_AW-1:0] WIN_BASE = 16'h4C00,
  localparam int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [WORD_W-1:0] rsp_action_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_win_o
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] match, remap, mask;
  logic [NUM_WIN-1:0][WORD_W-1:0] action;
  logic [WORD_W-1:0]              def_action;
  logic [NUM_WIN-1:0]             hit;

  ob_xlate_regs #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_AW(REG_AW),
    .MASK_LSB(MASK_LSB), .WIN_BASE(WIN_BASE)
  ) regs_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .match_o(match), .remap_o(remap), .mask_o(mask),
    .action_o(action), .def_action_o(def_action)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
    ob_xlate_hit #(.ADDR_W(ADDR_W)) hit_i (
      .addr_i(req_addr_i), .match_i(match[w]), .mask_i(mask[w]), .hit_o(hit[w])
    );
  end

  logic [ADDR_W-1:0] sel_addr;
  logic [WORD_W-1:0] sel_act;
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_win;

  ob_xlate_sel #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .ACT_W(WORD_W)) sel_i (
    .addr_i(req_addr_i), .hit_i(hit), .remap_i(remap), .mask_i(mask),
    .action_i(action), .def_action_i(def_action),
    .addr_o(sel_addr), .action_o(sel_act), .hit_o(sel_hit), .win_o(sel_win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_action_o <= '0;
      rsp_hit_o    <= 1'b0;
      rsp_win_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o   <= sel_addr;
        rsp_action_o <= sel_act;
        rsp_hit_o    <= sel_hit;
        rsp_win_o    <= sel_win;
      end
    end
  end
endmodule

// File: rtl/ob_xlate_sva.sv
module ob_xlate_sva #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned REG_AW   = 16,
  parameter int unsigned MASK_LSB = 16,
  parameter int unsigned IDX_W    = 3,
  parameter logic [REG_AW-1:0] WIN_BASE = 16'h4C00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic [31:0]       rsp_action_o,
  input logic              rsp_hit_o,
  input logic [IDX_W-1:0]  rsp_win_o
);
  localparam logic [REG_AW-1:0] MASK0_ADDR = WIN_BASE + REG_AW'(16);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R9
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(rsp_addr_o) && $stable(rsp_action_o) && $stable(rsp_hit_o))); // R9
  AST_MISS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_hit_o || rsp_addr_o == $past(req_addr_i))); // R8
  AST_LOW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_addr_o[MASK_LSB-1:0] == $past(req_addr_i[MASK_LSB-1:0]))); // R3
  AST_MASK_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == MASK0_ADDR) |-> (reg_rdata_o[MASK_LSB-1:0] == '0)); // R3
  AST_MISS_WIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_win_o == '0)); // R11
endmodule

bind ob_xlate ob_xlate_sva #(
  .ADDR_W(ADDR_W), .REG_AW(REG_AW), .MASK_LSB(MASK_LSB), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)
) sva_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o),
  .rsp_addr_o(rsp_addr_o), .rsp_action_o(rsp_action_o), .rsp_hit_o(rsp_hit_o),
  .rsp_win_o(rsp_win_o)
);

// File: tb/ob_xlate_tb_top.sv
module ob_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_action;
  logic        rsp_hit;
  logic [2:0]  rsp_win;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr),
    .rsp_action_o(rsp_action), .rsp_hit_o(rsp_hit), .rsp_win_o(rsp_win)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        hit;
    logic [2:0]  win;
    logic [63:0] xa;
    logic [31:0] act;
  } vec_t;

  // default action 0x40; W2 I/O 1 MiB, W3 memory 16 MiB, W7 config1 64 KiB, W0 disabled
  localparam vec_t VECS [8] = '{
    '{64'h0000_0000_2001_2345, 1'b1, 3'd2, 64'h0000_0080_5001_2345, 32'h0000_0904},
    '{64'h0000_0000_20AB_CDEF, 1'b1, 3'd3, 64'h0000_0001_00AB_CDEF, 32'h0000_00C0},
    '{64'h0000_0040_0000_BEEF, 1'b1, 3'd7, 64'h0000_0000_3000_BEEF, 32'h0000_0009},
    '{64'h0000_0000_1000_1234, 1'b0, 3'd0, 64'h0000_0000_1000_1234, 32'h0000_0040},
    '{64'h0000_0041_0000_BEEF, 1'b0, 3'd0, 64'h0000_0041_0000_BEEF, 32'h0000_0040},
    '{64'h0000_0000_2100_0000, 1'b0, 3'd0, 64'h0000_0000_2100_0000, 32'h0000_0040},
    '{64'h0000_0000_20FF_FFFF, 1'b1, 3'd3, 64'h0000_0001_00FF_FFFF, 32'h0000_00C0},
    '{64'h0000_0000_200F_FFFF, 1'b1, 3'd2, 64'h0000_0080_500F_FFFF, 32'h0000_0904}
  };

  function automatic logic [15:0] win_reg(input int w, input int k);
    return 16'h4C00 + 16'(w * 32) + 16'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win_cfg(input int w, input logic [63:0] m, input logic [63:0] r,
                         input logic [63:0] k, input logic [31:0] act);
    wr(win_reg(w, 8'h00), m[31:0]);  wr(win_reg(w, 8'h04), m[63:32]);
    wr(win_reg(w, 8'h08), r[31:0]);  wr(win_reg(w, 8'h0C), r[63:32]);
    wr(win_reg(w, 8'h10), k[31:0]);  wr(win_reg(w, 8'h14), k[63:32]);
    wr(win_reg(w, 8'h18), act);
  endtask

  // drive one request; returns with the registered response visible
  task automatic req(input logic [63:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_rsp(input string tag, input logic [63:0] xa, input logic [31:0] xact,
                         input logic xhit, input logic [2:0] xwin);
    chk(rsp_valid, tag, {63'd0, rsp_valid}, 64'd1);
    chk(rsp_addr == xa, tag, rsp_addr, xa);
    chk(rsp_action == xact, tag, {32'd0, rsp_action}, {32'd0, xact});
    chk(rsp_hit == xhit && rsp_win == xwin, tag, {60'd0, rsp_hit, rsp_win}, {60'd0, xhit, xwin});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(!rsp_valid, "R1 valid", {63'd0, rsp_valid}, 64'd0);
    rd(win_reg(3, 8'h18), d); chk(d == 0, "R1 action3", {32'd0, d}, 64'd0);
    rd(16'h4CFC, d);          chk(d == 0, "R1 default", {32'd0, d}, 64'd0);
    rd(win_reg(7, 8'h00), d); chk(d == 0, "R1 match7", {32'd0, d}, 64'd0);

    // program
    win_cfg(0, 64'h0000_0000_1000_0000, 64'h0000_0000_9999_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h4);
    win_cfg(2, 64'h0000_0000_2000_0001, 64'h0000_0080_5000_0000, 64'hFFFF_FFFF_FFF0_0000, 32'h904);
    win_cfg(3, 64'h0000_0000_2000_0001, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FF00_0000, 32'hC0);
    win_cfg(7, 64'h0000_0040_0000_0001, 64'h0000_0000_3000_0000, 64'hFFFF_FFFF_FFFF_0000, 32'h9);
    wr(16'h4CFC, 32'h40);

    // R2: readback and unmapped slots
    rd(win_reg(7, 8'h04), d); chk(d == 32'h40, "R2 match7 hi", {32'd0, d}, 64'h40);
    rd(win_reg(3, 8'h18), d); chk(d == 32'hC0, "R2 action3", {32'd0, d}, 64'hC0);
    rd(win_reg(2, 8'h0C), d); chk(d == 32'h80, "R2 remap2 hi", {32'd0, d}, 64'h80);
    rd(16'h4CFC, d);          chk(d == 32'h40, "R2 default", {32'd0, d}, 64'h40);
    wr(win_reg(1, 8'h1C), 32'hDEAD_BEEF);
    rd(win_reg(1, 8'h1C), d); chk(d == 0, "R2 spare slot", {32'd0, d}, 64'd0);
    wr(16'h4D00, 32'h1234_5678);
    rd(16'h4D00, d);          chk(d == 0, "R2 past map", {32'd0, d}, 64'd0);
    // R3: mask low bits
    rd(win_reg(0, 8'h10), d); chk(d == 32'hFFFF_0000, "R3 mask low", {32'd0, d}, 64'hFFFF_0000);

    // table walk: R5 R6 R8 R10 R11
    for (int i = 0; i < 8; i++) begin
      req(VECS[i].a);
      chk_rsp($sformatf("R5/R6/R8/R10/R11 vec%0d", i), VECS[i].xa, VECS[i].act, VECS[i].hit, VECS[i].win);
    end

    // R9: valid drops, outputs hold
    @(negedge clk);
    req_addr = 64'h0000_0040_0000_0000;
    @(negedge clk);
    chk(!rsp_valid, "R9 idle", {63'd0, rsp_valid}, 64'd0);
    chk(rsp_addr == 64'h0000_0080_500F_FFFF, "R9 hold", rsp_addr, 64'h0000_0080_500F_FFFF);

    // R4: enable window 0 via bit 0
    wr(win_reg(0, 8'h00), 32'h1000_0001);
    req(64'h0000_0000_1000_1234);
    chk_rsp("R4 enabled", 64'h0000_0000_9999_1234, 32'h4, 1'b1, 3'd0);
    win_cfg(0, 64'd0, 64'd0, 64'd0, 32'd0);
    req(64'h0000_0000_1000_1234);
    chk_rsp("R4 zeroed", 64'h0000_0000_1000_1234, 32'h40, 1'b0, 3'd0);

    // R7: window 0 overlaps windows 2 and 3
    win_cfg(0, 64'h0000_0000_2000_0001, 64'h4000_0000_0000_0000, 64'hFFFF_FFFF_E000_0000, 32'hC);
    req(64'h0000_0000_2001_2345);
    chk_rsp("R7 lowest wins", 64'h4000_0000_0001_2345, 32'hC, 1'b1, 3'd0);

    // R3: low bits preserved under remap with nonzero low remap bits
    wr(win_reg(7, 8'h08), 32'h3000_FFFF);
    req(64'h0000_0040_0000_1357);
    chk_rsp("R3 low keep", 64'h0000_0000_3000_1357, 32'h9, 1'b1, 3'd7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule